// File: doc/BRIEF.md
# I2C Write-Only Control Register Port

This block is a slave-only I2C front end that lets a host processor load a bank of thirty-two 8-bit control registers inside a video encoder. The bus lines are oversampled by the fast system clock (27 MHz in the target chip), which easily covers the 400 kbit/s fast-mode rate. The slave answers one 7-bit device address. One bit of that address, bit 1, comes from an external strap input, so two encoders can share a bus.

A write transfer has three parts. The first is the address byte. The next byte is a register pointer, of which only the low five bits count. Every byte after that is stored at the current pointer, and the pointer then advances by one. A long burst therefore fills consecutive registers and wraps from the top register back to register 0. Each stored byte also appears for one system clock on a write strobe, together with its register number and value.

A mode input hands the shared pins to an alternate serial port. While that input is high, the I2C logic stays idle and never drives SDA. While it is low, the spare serial output owned by the other port is held tristated.

Top module: `i2c_regport`

## Requirements
- R1: The slave acknowledges an address byte equal to {7'b10001_s_0, 1'b0}, where s is the strap input. This gives byte 0x88 when the strap is 0 and 0x8C when it is 1.
- R2: An address byte that does not match, or that has the read bit (bit 0) set, gets no acknowledge. No register is written until the next START.
- R3: The first byte after an accepted address is acknowledged and loads the pointer from its bits 4:0. Bits 7:5 are ignored, and this byte writes no register.
- R4: Each later byte is acknowledged and stored in the register the pointer selects. `wr_en` pulses for exactly one clock per stored byte, with `wr_addr` and `wr_data` valid, and `regs_o[8*k +: 8]` shows register k.
- R5: The pointer advances by one after each stored byte and wraps from 31 to 0.
- R6: The acknowledge (`sda_oe` high, which pulls SDA low) starts after the SCL fall that ends bit 8 and is released after the SCL fall that ends bit 9.
- R7: A STOP or START in the middle of a byte aborts the transfer and discards the partial byte. A START begins address matching again.
- R8: While `mode_alt` is high, the slave never acknowledges and never writes, and `so_hiz` is 0. While `mode_alt` is low, `so_hiz` is 1.
- R9: While `rst_n` is low, all registers and the pointer clear, and `sda_oe` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| mode_alt | input | 1 | 1 hands the pins to the alternate serial port and idles the I2C logic |
| strap | input | 1 | Strap that sets device address bit 1 |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| so_hiz | output | 1 | 1 holds the spare serial output at high impedance |
| wr_en | output | 1 | One-clock write strobe per stored byte |
| wr_addr | output | 5 | Register number of the stored byte |
| wr_data | output | 8 | Value of the stored byte |
| regs_o | output | 256 | Contents of the register bank, register k in bits 8k+7:8k |

## Verification
The assertions take for granted that each SCL phase lasts longer than the three clocks of synchroniser and edge-detect delay. Under that assumption, any change of the acknowledge driver falls inside an SCL low phase as seen at the pins. They also rely on each byte taking many system clocks, so two write strobes can never be adjacent. The bench drives every SCL and SDA phase for six system clocks, changes SDA only while SCL is low (except for deliberate START and STOP conditions), and holds `mode_alt` and `strap` steady for the whole of a transfer.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int NREG = 32,
  parameter logic [6:0] DEV_ADDR = 7'h44,
  parameter int STRAP_POS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_alt,
  input  logic                strap,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_oe,
  output logic                so_hiz,
  output logic                wr_en,
  output logic [$clog2(NREG)-1:0] wr_addr,
  output logic [7:0]          wr_data,
  output logic [NREG*8-1:0]   regs_o
);
  localparam int PW = $clog2(NREG);
  localparam logic [PW-1:0] PONE = 1;
  localparam logic [PW-1:0] PTOP = PW'(NREG - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKWAIT, S_ACKDRV, S_SKIP} state_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  state_t state;
  kind_t kind;
  logic [2:0] scl_p, sda_p;
  logic [6:0] shreg;
  logic [2:0] bitcnt;
  logic [PW-1:0] ptr;
  logic [7:0] regs [NREG];

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise = scl_s & ~scl_d;
  wire fall = ~scl_s & scl_d;
  wire [7:0] byte_w = {shreg, sda_s};
  wire [6:0] my_addr = DEV_ADDR | (7'(strap) << STRAP_POS);

  assign sda_oe = (state == S_ACKDRV);
  assign so_hiz = ~mode_alt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind    <= K_ADDR;
      shreg   <= '0;
      bitcnt  <= '0;
      ptr     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (mode_alt) begin
        state <= S_IDLE;
      end else if (start_c) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
      end else if (stop_c) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_RX: if (rise) begin
            shreg  <= byte_w[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              case (kind)
                K_ADDR: begin
                  if (byte_w[7:1] == my_addr && !byte_w[0]) begin
                    state <= S_ACKWAIT;
                    kind  <= K_PTR;
                  end else begin
                    state <= S_SKIP;
                  end
                end
                K_PTR: begin
                  ptr   <= byte_w[PW-1:0];
                  kind  <= K_DATA;
                  state <= S_ACKWAIT;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= byte_w;
                  ptr     <= (ptr == PTOP) ? '0 : ptr + PONE;
                  state   <= S_ACKWAIT;
                end
              endcase
            end
          end
          S_ACKWAIT: if (fall) state <= S_ACKDRV;
          S_ACKDRV: if (fall) begin
            state  <= S_RX;
            bitcnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_alt,
  input logic scl_in,
  input logic sda_oe,
  input logic wr_en
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R4
  AST_WR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !sda_oe); // R6
  AST_ACK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_in); // R6
  AST_ACK_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(sda_oe) |-> !scl_in); // R6
  AST_ALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mode_alt |=> !wr_en); // R8
  AST_ALT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) mode_alt |=> !sda_oe); // R8
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_alt(mode_alt),
  .scl_in(scl_in), .sda_oe(sda_oe), .wr_en(wr_en)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
  localparam int Q = 6;
  logic clk = 0, rst_n = 0, mode_alt = 0, strap = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, so_hiz, wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [255:0] regs_o;
  wire sda_bus = sda_m & ~sda_oe;
  logic [7:0] model [32];
  int checks = 0, errors = 0, wr_cnt = 0;

  i2c_regport uut (.clk(clk), .rst_n(rst_n), .mode_alt(mode_alt), .strap(strap),
    .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe), .so_hiz(so_hiz),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .regs_o(regs_o));

  always #10 clk = ~clk;
  always @(negedge clk) if (wr_en) wr_cnt++;

  function automatic logic [7:0] dev_byte(input logic s);
    return {5'b10001, s, 1'b0, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic qd; repeat (Q) @(negedge clk); endtask

  task automatic bank_chk(input string req);
    int bad = -1;
    for (int k = 31; k >= 0; k--) if (regs_o[k*8 +: 8] !== model[k]) bad = k;
    if (bad < 0) chk(1, req, "bank", 0, 0);
    else chk(0, req, $sformatf("reg %0d", bad), int'(regs_o[bad*8 +: 8]), int'(model[bad]));
  endtask

  task automatic do_start; sda_m = 1; qd; scl_m = 1; qd; sda_m = 0; qd; scl_m = 0; qd; endtask
  task automatic do_stop; sda_m = 0; qd; scl_m = 1; qd; sda_m = 1; qd; endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qd; scl_m = 1; qd; qd; scl_m = 0; qd;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; qd; scl_m = 1; qd;
    ack = !sda_bus;
    qd; scl_m = 0; qd;
    chk(sda_oe == 0, "R6", "ack released", int'(sda_oe), 0);
  endtask

  task automatic burst(input logic [7:0] abyte, input logic [7:0] pbyte, input int n,
                       input bit accept, input string req);
    bit ack;
    int w0 = wr_cnt;
    logic [4:0] p = pbyte[4:0];
    logic [7:0] d;
    do_start;
    send_byte(abyte, ack);
    chk(ack == accept, accept ? "R1" : req, "address ack", int'(ack), int'(accept));
    send_byte(pbyte, ack);
    chk(ack == accept, "R3", "pointer ack", int'(ack), int'(accept));
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack);
      chk(ack == accept, "R4", "data ack", int'(ack), int'(accept));
      if (accept) begin model[p] = d; p = p + 5'd1; end
    end
    do_stop;
    repeat (4) @(negedge clk);
    chk(wr_cnt - w0 == (accept ? n : 0), accept ? "R4" : req, "strobe count", wr_cnt - w0, accept ? n : 0);
    bank_chk(accept ? "R5" : req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "timeout", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    int w0;
    void'($urandom(32'd1234));
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    repeat (50) @(negedge clk);
    chk(sda_oe == 0 && wr_en == 0, "R9", "idle outputs in reset", int'(sda_oe), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    bank_chk("R9");
    chk(so_hiz == 1, "R8", "spare tristated in I2C mode", int'(so_hiz), 1);

    // R1 both strap values, R3 high pointer bits ignored
    strap = 0; burst(8'h88, 8'hE3, 2, 1, "R1");
    strap = 1; burst(8'h8C, 8'h40, 3, 1, "R1");
    burst(8'h88, 8'h10, 2, 0, "R2");
    strap = 0;
    burst(8'h89, 8'h10, 2, 0, "R2");
    // R5 wrap
    burst(8'h88, 8'h1E, 4, 1, "R5");

    // R7 repeated START mid-byte
    w0 = wr_cnt;
    do_start; send_byte(8'h88, ack); send_byte(8'h05, ack);
    send_byte(8'hA5, ack); model[5] = 8'hA5;
    send_bits(8'h3C, 4);
    do_start; send_byte(8'h88, ack);
    chk(ack == 1, "R7", "address after restart", int'(ack), 1);
    send_byte(8'h09, ack); send_byte(8'h5A, ack); model[9] = 8'h5A;
    do_stop; repeat (4) @(negedge clk);
    chk(wr_cnt - w0 == 2, "R7", "writes around restart", wr_cnt - w0, 2);
    bank_chk("R7");
    // R7 STOP mid-byte
    w0 = wr_cnt;
    do_start; send_byte(8'h88, ack); send_byte(8'h0C, ack);
    send_bits(8'hFF, 3);
    do_stop; repeat (4) @(negedge clk);
    chk(wr_cnt == w0, "R7", "no write after stop abort", wr_cnt - w0, 0);
    bank_chk("R7");
    burst(8'h88, 8'h0C, 1, 1, "R7");

    // R8 alternate mode
    mode_alt = 1; repeat (4) @(negedge clk);
    chk(so_hiz == 0, "R8", "spare driven in alt mode", int'(so_hiz), 0);
    burst(8'h88, 8'h02, 3, 0, "R8");
    mode_alt = 0; repeat (4) @(negedge clk);

    // random mix
    for (int it = 0; it < 20; it++) begin
      logic [7:0] a;
      bit good;
      strap = 1'($urandom);
      good = ($urandom % 10) < 7;
      a = good ? dev_byte(strap) : 8'($urandom);
      if (!good && a == dev_byte(strap)) a[0] = 1'b1;
      burst(a, 8'($urandom), 1 + ($urandom % 6), good, good ? "R4" : "R2");
    end

    // R9 reset mid-run
    rst_n = 0; repeat (50) @(negedge clk);
    rst_n = 1; repeat (5) @(negedge clk);
    for (int k = 0; k < 32; k++) model[k] = 8'h00;
    bank_chk("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule